// File: doc/BRIEF.md
# UART Transmit Character Sequencer with Break and Insert

This block sits between the transmit character buffer of a UART and its bit serialiser, and decides which character goes out next. Ordinary buffer traffic arrives on a valid/ready stream and passes to the serialiser through a valid/ready handoff. The serialiser raises `ser_ready` only when it is idle at a character boundary.

Software can place one out-of-band control character, such as a flow-control XON or XOFF, into a holding slot. The sequencer sends that character at the next boundary, ahead of any further buffer character. A character already in flight is never cut, so the buffer contents stay intact.

A stop command ends normal traffic with a programmable number of break characters. The sequencer forces the line low for whole character frames, counting bit ticks from the baud generator against the programmed frame length. It then parks the line at idle. Buffer traffic stays halted until a restart command is given, although inserted control characters can still be sent while halted.

Top module: `uart_tx_inject_seq`

## Requirements
- R1: After reset, `ins_pending`, `line_brk`, `tx_halted` and `ser_valid` are all 0.
- R2: With no insert and no stop pending, buffer characters reach the serialiser unchanged, in arrival order, with `ser_ins` = 0. `buf_ready` follows `ser_ready`.
- R3: A pending insert character is offered with `ser_ins` = 1 at the next boundary, before any further buffer character. `buf_ready` is 0 while an insert is pending.
- R4: A write to `ins_wr` sets `ins_pending`. The flag clears in the cycle after the serialiser accepts the inserted character. A write made while the flag is already set is ignored, and the earlier character is the one that is sent.
- R5: A stop request waits until the serialiser is idle (`ser_ready` = 1) and no insert is pending. `line_brk` never rises while the serialiser is busy.
- R6: A break lasts exactly `brk_count` × `frame_bits` bit ticks. During that time `line_brk` = 1, which means the line is held at 0 for every bit of every frame, start and stop positions included.
- R7: A stop with `brk_count` = 0 sends no break: `line_brk` stays 0 and the block goes straight to halted.
- R8: While `line_brk` = 1, both `buf_ready` and `ser_valid` are 0.
- R9: When halted (`tx_halted` = 1), `line_brk` is 0, buffer characters are not accepted, and a pending insert is still sent.
- R10: `restart_cmd` while halted resumes buffer traffic.
- R11: If an insert is pending when the stop boundary is reached, the insert is sent first and the break follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_valid | input | 1 | Buffer character available |
| buf_data | input | DATA_W | Buffer character |
| buf_ready | output | 1 | Buffer character accepted this cycle when valid |
| ins_wr | input | 1 | Write strobe for the insert slot |
| ins_data | input | DATA_W | Character to insert |
| ins_pending | output | 1 | Insert slot occupied |
| stop_cmd | input | 1 | Stop-transmit request pulse |
| restart_cmd | input | 1 | Restart request pulse, acted on only when halted |
| brk_count | input | CNT_W | Number of break characters per stop |
| frame_bits | input | FB_W | Bits per character frame (at least 1) |
| bit_tick | input | 1 | One pulse per bit time |
| ser_valid | output | 1 | Character offered to the serialiser |
| ser_data | output | DATA_W | Offered character |
| ser_ins | output | 1 | Offered character comes from the insert slot |
| ser_ready | input | 1 | Serialiser idle at a character boundary |
| line_brk | output | 1 | Force the transmit line low |
| tx_halted | output | 1 | Buffer traffic halted after a stop |

## Verification
The bench injects a control character while a buffer character is still being serialised. It checks that the insert is the very next character out, with the neighbouring buffer characters unchanged. A design that pre-empted the frame, or let the buffer win the boundary, would reorder or lose characters. It counts bit ticks under `line_brk` for two frame lengths and counts, and also for a count of zero. An off-by-one in the frame or character counter would show up as a tick total that is too long or too short, and a zero count that wrapped would produce a very long break. It issues a stop while the serialiser is busy and while an insert is pending, where a careless design would drop the line low mid-frame or swallow the control character. It also checks that a second write to an occupied slot does not overwrite the first.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BREAK = 2'd1,
        ST_HALT  = 2'd2
    } txs_state_e;

    typedef struct packed {
        txs_state_e state;
        logic       stop;
    } txs_ctrl_t;

endpackage

// File: rtl/txs_ins_slot.sv
module txs_ins_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              pend,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take) begin
            slot_d.pend = 1'b0;
        end
        // a write into an occupied slot is dropped
        if (wr && !slot_q.pend) begin
            slot_d.pend = 1'b1;
            slot_d.data = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pend = slot_q.pend;
    assign data = slot_q.data;

    p_ins_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.pend && take && !wr) |=> !slot_q.pend);

    p_ins_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.pend && !take) |=> (slot_q.pend && $stable(slot_q.data)));

endmodule

// File: rtl/txs_brk_timer.sv
module txs_brk_timer #(
    parameter int CNT_W = 16,
    parameter int FB_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic [FB_W-1:0]  frame_bits,
    input  logic             tick,
    output logic             active,
    output logic             done
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] chars;
        logic [FB_W-1:0]  bits;
        logic [FB_W-1:0]  frame;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [FB_W-1:0] frame_safe;
    logic            last_bit;

    assign frame_safe = (frame_bits == '0) ? FB_W'(1) : frame_bits;
    assign last_bit   = (tmr_q.bits == FB_W'(1));

    always_comb begin
        tmr_d = tmr_q;
        done  = 1'b0;
        if (!tmr_q.active) begin
            if (start && count != '0) begin
                tmr_d.active = 1'b1;
                tmr_d.chars  = count;
                tmr_d.bits   = frame_safe;
                tmr_d.frame  = frame_safe;
            end
        end else if (tick) begin
            if (last_bit) begin
                if (tmr_q.chars == CNT_W'(1)) begin
                    tmr_d.active = 1'b0;
                    tmr_d.chars  = '0;
                    tmr_d.bits   = '0;
                    done         = 1'b1;
                end else begin
                    tmr_d.chars = tmr_q.chars - CNT_W'(1);
                    tmr_d.bits  = tmr_q.frame;
                end
            end else begin
                tmr_d.bits = tmr_q.bits - FB_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active = tmr_q.active;

    p_bits_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.active |-> (tmr_q.bits != '0 && tmr_q.chars != '0));

    p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && !tick) |=> ($stable(tmr_q.bits) && $stable(tmr_q.chars)));

endmodule

// File: rtl/uart_tx_inject_seq.sv
module uart_tx_inject_seq #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int FB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    output logic              buf_ready,
    input  logic              ins_wr,
    input  logic [DATA_W-1:0] ins_data,
    output logic              ins_pending,
    input  logic              stop_cmd,
    input  logic              restart_cmd,
    input  logic [CNT_W-1:0]  brk_count,
    input  logic [FB_W-1:0]   frame_bits,
    input  logic              bit_tick,
    output logic              ser_valid,
    output logic [DATA_W-1:0] ser_data,
    output logic              ser_ins,
    input  logic              ser_ready,
    output logic              line_brk,
    output logic              tx_halted
);
    import txs_pkg::*;

    txs_ctrl_t ctl_d, ctl_q;

    logic              slot_pend;
    logic [DATA_W-1:0] slot_data;
    logic              slot_take;
    logic              brk_start;
    logic              tmr_active;
    logic              tmr_done;

    txs_ins_slot #(.DATA_W(DATA_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ins_wr),
        .wdata (ins_data),
        .take  (slot_take),
        .pend  (slot_pend),
        .data  (slot_data)
    );

    txs_brk_timer #(.CNT_W(CNT_W), .FB_W(FB_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (brk_start),
        .count      (brk_count),
        .frame_bits (frame_bits),
        .tick       (bit_tick),
        .active     (tmr_active),
        .done       (tmr_done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        buf_ready = 1'b0;
        ser_valid = 1'b0;
        ser_data  = buf_data;
        ser_ins   = 1'b0;
        brk_start = 1'b0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (stop_cmd) begin
                    ctl_d.stop = 1'b1;
                end
                if (slot_pend) begin
                    ser_valid = 1'b1;
                    ser_data  = slot_data;
                    ser_ins   = 1'b1;
                end else if (ctl_q.stop) begin
                    if (ser_ready) begin
                        ctl_d.stop = 1'b0;
                        if (brk_count == '0) begin
                            ctl_d.state = ST_HALT;
                        end else begin
                            brk_start   = 1'b1;
                            ctl_d.state = ST_BREAK;
                        end
                    end
                end else begin
                    ser_valid = buf_valid;
                    buf_ready = ser_ready;
                end
            end
            ST_BREAK: begin
                if (tmr_done) begin
                    ctl_d.state = ST_HALT;
                end
            end
            ST_HALT: begin
                if (slot_pend) begin
                    ser_valid = 1'b1;
                    ser_data  = slot_data;
                    ser_ins   = 1'b1;
                end
                if (restart_cmd) begin
                    ctl_d.state = ST_RUN;
                end
            end
            default: begin
                ctl_d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_RUN, stop: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign slot_take   = ser_valid && ser_ready && ser_ins;
    assign ins_pending = slot_pend;
    assign line_brk    = tmr_active;
    assign tx_halted   = (ctl_q.state == ST_HALT);

    p_brk_at_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_active) |-> $past(ser_ready));

    p_ins_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pend |-> !buf_ready);

    p_brk_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_active |-> (!buf_ready && !ser_valid));

    p_halt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_HALT) |-> (!tmr_active && !buf_ready));

    p_brk_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_active |-> (ctl_q.state == ST_BREAK));

endmodule

// File: tb/uart_tx_inject_seq_bench.sv
module uart_tx_inject_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int CW   = 16;
    localparam int FW   = 4;
    localparam int BUSY = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_valid = 1'b0;
    logic [DW-1:0] buf_data = '0;
    logic          buf_ready;
    logic          ins_wr = 1'b0;
    logic [DW-1:0] ins_data = '0;
    logic          ins_pending;
    logic          stop_cmd = 1'b0;
    logic          restart_cmd = 1'b0;
    logic [CW-1:0] brk_count = '0;
    logic [FW-1:0] frame_bits = 4'd10;
    logic          bit_tick = 1'b0;
    logic          ser_valid;
    logic [DW-1:0] ser_data;
    logic          ser_ins;
    logic          ser_ready;
    logic          line_brk;
    logic          tx_halted;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0] log_data [64];
    logic          log_ins  [64];
    int            log_n = 0;
    int            busy  = 0;
    int            tdiv  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_inject_seq #(.DATA_W(DW), .CNT_W(CW), .FB_W(FW)) u_uart_tx_inject_seq (
        .clk(clk), .rst_n(rst_n),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_ready(buf_ready),
        .ins_wr(ins_wr), .ins_data(ins_data), .ins_pending(ins_pending),
        .stop_cmd(stop_cmd), .restart_cmd(restart_cmd),
        .brk_count(brk_count), .frame_bits(frame_bits), .bit_tick(bit_tick),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ins(ser_ins),
        .ser_ready(ser_ready), .line_brk(line_brk), .tx_halted(tx_halted)
    );

    // serialiser model: busy for BUSY cycles after each accepted character
    assign ser_ready = (busy == 0);
    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 0;
        end else if (ser_valid && ser_ready) begin
            if (log_n < 64) begin
                log_data[log_n] <= ser_data;
                log_ins[log_n]  <= ser_ins;
            end
            log_n <= log_n + 1;
            busy  <= BUSY;
        end else if (busy > 0) begin
            busy <= busy - 1;
        end
    end

    // bit tick every 4 clocks
    always @(posedge clk) begin
        tdiv     <= (tdiv == 3) ? 0 : tdiv + 1;
        bit_tick <= (tdiv == 3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge clk);
        buf_valid = 1'b1;
        buf_data  = d;
        while (1) begin
            #1;
            if (buf_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        buf_valid = 1'b0;
    endtask

    task automatic write_ins(input logic [DW-1:0] d);
        @(negedge clk);
        ins_wr = 1'b1;
        ins_data = d;
        @(negedge clk);
        ins_wr = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart_cmd = 1'b1;
        @(negedge clk);
        restart_cmd = 1'b0;
    endtask

    task automatic settle();
        repeat (2 * BUSY + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 ins_pending", ins_pending, 0);
        chk("R1 line_brk", line_brk, 0);
        chk("R1 tx_halted", tx_halted, 0);
        chk("R1 ser_valid", ser_valid, 0);
    endtask

    task automatic t_pass();
        int base = log_n;
        push(8'hA1); push(8'h5C); push(8'h07);
        settle();
        chk("R2 count", log_n - base, 3);
        chk("R2 c0", log_data[base], 8'hA1);
        chk("R2 c1", log_data[base+1], 8'h5C);
        chk("R2 c2", log_data[base+2], 8'h07);
        chk("R2 tag", {log_ins[base], log_ins[base+1], log_ins[base+2]}, 0);
    endtask

    task automatic t_insert_mid();
        int base = log_n;
        push(8'h31);
        write_ins(8'h13);
        chk("R4 pending set", ins_pending, 1);
        @(negedge clk);
        buf_valid = 1'b1;
        buf_data  = 8'h32;
        #1;
        chk("R3 buf_ready low while pending", buf_ready, 0);
        push(8'h32);
        settle();
        chk("R3 count", log_n - base, 3);
        chk("R3 first buf", log_data[base], 8'h31);
        chk("R3 insert next", log_data[base+1], 8'h13);
        chk("R3 insert tag", log_ins[base+1], 1);
        chk("R3 buffer after", log_data[base+2], 8'h32);
        chk("R4 pending cleared", ins_pending, 0);
    endtask

    task automatic t_insert_overwrite();
        int base = log_n;
        push(8'h40);
        write_ins(8'h13);
        write_ins(8'h11);
        settle();
        chk("R4 one insert", log_n - base, 2);
        chk("R4 first kept", log_data[base+1], 8'h13);
    endtask

    task automatic t_break(input logic [CW-1:0] cnt, input logic [FW-1:0] fb);
        int ticks = 0;
        int bad = 0;
        int saw_busy_low = 0;
        int base;
        brk_count  = cnt;
        frame_bits = fb;
        push(8'h55);
        pulse_stop();
        // serialiser still busy here
        while (!ser_ready) begin
            if (line_brk) saw_busy_low++;
            @(negedge clk);
        end
        chk("R5 no break while busy", saw_busy_low, 0);
        base = log_n;
        buf_valid = 1'b1;
        buf_data  = 8'hEE;
        for (int i = 0; i < 2000 && !tx_halted; i++) begin
            if (line_brk && bit_tick) ticks++;
            if (line_brk && (buf_ready || ser_valid)) bad++;
            @(negedge clk);
        end
        chk("R6 break ticks", ticks, cnt * fb);
        chk("R8 quiet in break", bad, 0);
        chk("R9 halted", tx_halted, 1);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (line_brk || buf_ready) bad++;
            @(negedge clk);
        end
        chk("R9 idle and closed when halted", bad, 0);
        buf_valid = 1'b0;
        chk("R9 nothing taken", log_n - base, 0);
    endtask

    task automatic t_halt_insert_restart();
        int base = log_n;
        write_ins(8'h11);
        settle();
        chk("R9 insert sent halted", log_n - base, 1);
        chk("R9 insert data", log_data[base], 8'h11);
        pulse_restart();
        chk("R10 resumed", tx_halted, 0);
        push(8'h66);
        settle();
        chk("R10 buffer flows", log_data[base+1], 8'h66);
    endtask

    task automatic t_zero_break();
        int seen = 0;
        brk_count = '0;
        pulse_stop();
        for (int i = 0; i < 40; i++) begin
            if (line_brk) seen++;
            @(negedge clk);
        end
        chk("R7 no break", seen, 0);
        chk("R7 halted", tx_halted, 1);
        pulse_restart();
    endtask

    task automatic t_insert_before_break();
        int base = log_n;
        int brk_seen_early = 0;
        brk_count  = 16'd1;
        frame_bits = 4'd8;
        push(8'h70);
        @(negedge clk);
        ins_wr = 1'b1; ins_data = 8'h13; stop_cmd = 1'b1;
        @(negedge clk);
        ins_wr = 1'b0; stop_cmd = 1'b0;
        for (int i = 0; i < 200 && !tx_halted; i++) begin
            if (line_brk && (log_n - base) < 2) brk_seen_early++;
            @(negedge clk);
        end
        chk("R11 insert sent", log_n - base, 2);
        chk("R11 insert data", log_data[base+1], 8'h13);
        chk("R11 break after insert", brk_seen_early, 0);
        pulse_restart();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass();
        t_insert_mid();
        t_insert_overwrite();
        t_break(16'd3, 4'd10);
        t_halt_insert_restart();
        t_break(16'd2, 4'd7);
        pulse_restart();
        t_zero_break();
        t_insert_before_break();
        summary();
        $finish;
    end

endmodule